// File: doc/BRIEF.md
# Protection Lookaside Address Checker

The block checks each memory access of one core against a small table of protection entries and the fixed region rules of the address map. An entry is a base address and an attribute word. The attribute word carries a valid bit, a page size and the user and supervisor permission bits. Every valid entry is compared with the address in the same cycle. The block counts the entries that hit and collects the permission failures. It then reports one exception class: none, miss, protection violation, multiple hit or misaligned. Some data accesses call for a hardware-error pulse instead of an exception, and the block raises that pulse for them.

A request is one cycle of `req` with the access attributes. The result appears on the next cycle with `rsp_valid`. On that same edge the fault status and fault address registers capture the access, but only when an exception is raised. A control path loads entry bases, entry attributes and the global enable, one word per cycle. The exception controller acts on `exc_code` and lies outside the block.

The control state machine has two states. ST_IDLE means no result is pending. ST_REPORT presents a result for one cycle. There are three transitions. ST_IDLE goes to ST_REPORT on `req`. ST_REPORT goes back to ST_REPORT on a further `req`. ST_REPORT returns to ST_IDLE when `req` is low.

Top module: `prot_lookaside_chk`

## Requirements
- R1: After reset, the global enable is 1, all entries are invalid (attribute 0, base 0), all four fault registers read 0, and `rsp_valid`, `exc_code` and `hw_err` are 0.
- R2: A `req` sampled at a rising edge makes `rsp_valid` 1 for the following cycle (ST_IDLE to ST_REPORT). `rsp_valid` is 0 in any cycle whose previous edge had no `req`.
- R3: An entry takes part only when attribute bit 0 (valid) is set. Attribute bits 17:16 pick the page size: 0 = 1 KB, 1 = 4 KB, 2 = 1 MB, 3 = 4 MB. The entry hits when base <= address < base + size.
- R4: A write to a hit entry is a protection violation in any of three cases: it is a user write and attribute bit 3 (user write) is clear; it is a supervisor write and bit 4 (supervisor write) is clear; or bit 12 (L1 cacheable) is set while bit 14 (write-through) and bit 7 (dirty) are both clear.
- R5: A user read of a hit entry whose attribute bit 2 (user read) is clear is a protection violation. Supervisor reads are never refused by an entry.
- R6: An access is misaligned when address & (2^req_size - 1) is nonzero (req_size 0..3 gives 1, 2, 4 or 8 bytes). This gives the misaligned class ahead of every other outcome.
- R7: With the enable set, two or more hits give the multiple-hit class even when a permission fails. Exactly one hit with a permission failure gives a protection violation. Zero hits outside the implicit regions gives a miss.
- R8: `exc_code` is {req_inst, class}, where class is 0 none, 1 miss, 2 protection, 3 multiple hit and 4 misaligned. Data faults are therefore 1..4 and instruction faults 9..12. `exc_code` is 0 whenever `rsp_valid` is 0.
- R9: On an exception, the side's fault address takes the address. The side's fault status takes bit 19 = miss, 18 = `req_dag1`, 17 = `req_supv`, 16 = `req_write`, and bits 15:0 = the mask of hit entries (0 when disabled). Without an exception the fault registers hold.
- R10: When the written control bit 0 is 0, the access counts as one hit and only the implicit region rules apply.
- R11: At or above 0xFFC00000, an instruction fetch is a miss. A data access there from user mode, or with `req_dag1` set, is a protection violation. A supervisor primary data access there is allowed.
- R12: Within 0xFF000000..0xFFBFFFFF, an instruction fetch outside 0xFFA00000..0xFFAFFFFF is a protection violation. A data access inside that 1 MB region pulses `hw_err` with `exc_code` 0 and logs nothing. The other implicit cases defer to the entry result.
- R13: A data-side exception also loads the instruction fault address with `req_pc` and the instruction fault status with `req_supv` at bit 17 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 entry base, 1 entry attribute, 2 control |
| cfg_idx | input | 4 | Entry index for base and attribute writes |
| cfg_wdata | input | 32 | Write data |
| req | input | 1 | Access check request strobe |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 for a write |
| req_inst | input | 1 | 1 for an instruction fetch |
| req_size | input | 2 | log2 of access size in bytes |
| req_supv | input | 1 | 1 in supervisor mode |
| req_dag1 | input | 1 | 1 when issued by the secondary address generator |
| req_pc | input | 32 | Program counter of the access |
| rsp_valid | output | 1 | Result valid, one cycle after `req` |
| exc_code | output | 4 | Exception code |
| hw_err | output | 1 | Hardware-error pulse |
| d_fault_status | output | 32 | Data fault status |
| d_fault_addr | output | 32 | Data fault address |
| i_fault_status | output | 32 | Instruction fault status |
| i_fault_addr | output | 32 | Instruction fault address |

## Verification
The bench uses the default build: 16 entries, a system base of 0xFFC00000 and the L1 tags 0xFF and 0xFFA. With all 16 entries, the random bases can be packed into four narrow windows, so overlapping pages and multiple-hit masks with several bits set occur often. Two of the windows sit in the L1 space, which makes entry hits collide with the implicit rules. Random addresses fall on page limits, into the system region and onto misaligned offsets. Periodic enable toggles cover both the table path and the implicit-only path.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int AW = 32;

    // Exception class, low three bits of the exception code
    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_MISS  = 3'd1,
        CLS_PROT  = 3'd2,
        CLS_MHIT  = 3'd3,
        CLS_MISAL = 3'd4
    } exc_cls_e;

    // Outcome of the fixed region rules
    typedef enum logic [2:0] {
        IMP_NONE,
        IMP_OK,
        IMP_MISS,
        IMP_PROT,
        IMP_HWERR
    } imp_res_e;

    typedef enum logic {
        ST_IDLE,
        ST_REPORT
    } ptc_state_e;

    // Configuration write targets
    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_ATTR = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    // Attribute word bit positions
    localparam int AB_VALID = 0;
    localparam int AB_URD   = 2;
    localparam int AB_UWR   = 3;
    localparam int AB_SWR   = 4;
    localparam int AB_DIRTY = 7;
    localparam int AB_L1C   = 12;
    localparam int AB_WT    = 14;
    localparam int AB_PG    = 16;

    typedef struct packed {
        logic [1:0] pg;
        logic       wt;
        logic       l1c;
        logic       dirty;
        logic       swr;
        logic       uwr;
        logic       urd;
        logic       valid;
    } ent_attr_t;

    function automatic logic [AW:0] page_bytes(input logic [1:0] pg);
        unique case (pg)
            2'd0:    page_bytes = (AW+1)'(33'h0_0000_0400);
            2'd1:    page_bytes = (AW+1)'(33'h0_0000_1000);
            2'd2:    page_bytes = (AW+1)'(33'h0_0010_0000);
            default: page_bytes = (AW+1)'(33'h0_0040_0000);
        endcase
    endfunction

endpackage

// File: rtl/ptc_entry.sv
module ptc_entry
    import ptc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_base,
    input  logic          we_attr,
    input  logic [AW-1:0] wdata,
    input  logic [AW-1:0] addr,
    input  logic          write,
    input  logic          supv,
    output logic          hit,
    output logic          perm_fail
);

    logic [AW-1:0] base_q;
    ent_attr_t     attr_q;
    logic [AW:0]   limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            attr_q <= '0;
        end else begin
            if (we_base) base_q <= wdata;
            if (we_attr) begin
                attr_q.valid <= wdata[AB_VALID];
                attr_q.urd   <= wdata[AB_URD];
                attr_q.uwr   <= wdata[AB_UWR];
                attr_q.swr   <= wdata[AB_SWR];
                attr_q.dirty <= wdata[AB_DIRTY];
                attr_q.l1c   <= wdata[AB_L1C];
                attr_q.wt    <= wdata[AB_WT];
                attr_q.pg    <= wdata[AB_PG+1:AB_PG];
            end
        end
    end

    assign limit = {1'b0, base_q} + page_bytes(attr_q.pg);

    always_comb begin
        hit = attr_q.valid && (addr >= base_q) && ({1'b0, addr} < limit);
        perm_fail = 1'b0;
        if (hit) begin
            if (write) begin
                if (!supv && !attr_q.uwr) perm_fail = 1'b1;
                if (supv && !attr_q.swr)  perm_fail = 1'b1;
                if (attr_q.l1c && !attr_q.wt && !attr_q.dirty) perm_fail = 1'b1;
            end else if (!supv && !attr_q.urd) begin
                perm_fail = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ptc_implicit.sv
module ptc_implicit
    import ptc_pkg::*;
#(
    parameter logic [AW-1:0] SYS_BASE = 32'hFFC0_0000,
    parameter logic [7:0]    L1_TAG   = 8'hFF,
    parameter logic [11:0]   EXEC_TAG = 12'hFFA
) (
    input  logic [AW-1:0] addr,
    input  logic          inst,
    input  logic          supv,
    input  logic          dag1,
    output imp_res_e      res
);

    logic in_l1, in_exec;

    assign in_l1   = (addr[AW-1:AW-8]  == L1_TAG);
    assign in_exec = (addr[AW-1:AW-12] == EXEC_TAG);

    always_comb begin
        res = IMP_NONE;
        if (addr >= SYS_BASE) begin
            if (inst)              res = IMP_MISS;
            else if (!supv || dag1) res = IMP_PROT;
            else                   res = IMP_OK;
        end else if (in_l1) begin
            if (inst) res = in_exec ? IMP_OK : IMP_PROT;
            else      res = in_exec ? IMP_HWERR : IMP_OK;
        end
    end

endmodule

// File: rtl/prot_lookaside_chk.sv
module prot_lookaside_chk
    import ptc_pkg::*;
#(
    parameter int            N_ENT    = 16,
    parameter logic [31:0]   SYS_BASE = 32'hFFC0_0000,
    parameter logic [7:0]    L1_TAG   = 8'hFF,
    parameter logic [11:0]   EXEC_TAG = 12'hFFA,
    localparam int           IDX_W    = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [31:0]      cfg_wdata,
    input  logic             req,
    input  logic [31:0]      req_addr,
    input  logic             req_write,
    input  logic             req_inst,
    input  logic [1:0]       req_size,
    input  logic             req_supv,
    input  logic             req_dag1,
    input  logic [31:0]      req_pc,
    output logic             rsp_valid,
    output logic [3:0]       exc_code,
    output logic             hw_err,
    output logic [31:0]      d_fault_status,
    output logic [31:0]      d_fault_addr,
    output logic [31:0]      i_fault_status,
    output logic [31:0]      i_fault_addr
);

    logic [N_ENT-1:0] hit_vec, fail_vec;
    logic             en_q;
    int               nhit;
    imp_res_e         imp;
    exc_cls_e         cls;
    logic             herr, log_it, misal;
    logic [2:0]       size_mask;
    logic [15:0]      hit_mask;
    ptc_state_e       state_q, state_d;
    logic [3:0]       exc_q;
    logic             hwerr_q;

    // ---------------- entry table ----------------
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        ptc_entry u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_base   (cfg_we && cfg_sel == SEL_BASE && cfg_idx == IDX_W'(g)),
            .we_attr   (cfg_we && cfg_sel == SEL_ATTR && cfg_idx == IDX_W'(g)),
            .wdata     (cfg_wdata),
            .addr      (req_addr),
            .write     (req_write),
            .supv      (req_supv),
            .hit       (hit_vec[g]),
            .perm_fail (fail_vec[g])
        );
    end

    ptc_implicit #(
        .SYS_BASE (SYS_BASE),
        .L1_TAG   (L1_TAG),
        .EXEC_TAG (EXEC_TAG)
    ) u_imp (
        .addr (req_addr),
        .inst (req_inst),
        .supv (req_supv),
        .dag1 (req_dag1),
        .res  (imp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              en_q <= 1'b1;
        else if (cfg_we && cfg_sel == SEL_CTRL)  en_q <= cfg_wdata[0];
    end

    // ---------------- classification ----------------
    always_comb begin
        nhit = 0;
        for (int i = 0; i < N_ENT; i++) nhit += int'(hit_vec[i]);
        size_mask = 3'((4'd1 << req_size) - 4'd1);
        misal     = |(req_addr[2:0] & size_mask);
        hit_mask  = '0;
        if (en_q) hit_mask[N_ENT-1:0] = hit_vec;
    end

    always_comb begin
        cls    = CLS_NONE;
        herr   = 1'b0;
        log_it = 1'b0;
        if (misal) begin
            cls = CLS_MISAL;  log_it = 1'b1;
        end else if (en_q && ((|fail_vec) || nhit >= 2)) begin
            cls = (nhit >= 2) ? CLS_MHIT : CLS_PROT;  log_it = 1'b1;
        end else begin
            unique case (imp)
                IMP_OK:    ;
                IMP_NONE:  if (en_q && nhit != 1) begin cls = CLS_MISS; log_it = 1'b1; end
                IMP_MISS:  begin cls = CLS_MISS; log_it = 1'b1; end
                IMP_PROT:  begin cls = CLS_PROT; log_it = 1'b1; end
                IMP_HWERR: herr = 1'b1;
                default:   ;
            endcase
        end
    end

    // ---------------- state register and result capture ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req) state_d = ST_REPORT;
            ST_REPORT: state_d = req ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_q          <= '0;
            hwerr_q        <= 1'b0;
            d_fault_status <= '0;
            d_fault_addr   <= '0;
            i_fault_status <= '0;
            i_fault_addr   <= '0;
        end else if (req) begin
            exc_q   <= {req_inst, cls};
            hwerr_q <= herr;
            if (log_it) begin
                if (req_inst) begin
                    i_fault_addr   <= req_addr;
                    i_fault_status <= {12'd0, cls == CLS_MISS, req_dag1, req_supv, req_write, hit_mask};
                end else begin
                    d_fault_addr   <= req_addr;
                    d_fault_status <= {12'd0, cls == CLS_MISS, req_dag1, req_supv, req_write, hit_mask};
                    i_fault_addr   <= req_pc;
                    i_fault_status <= {14'd0, req_supv, 17'd0};
                end
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        rsp_valid = (state_q == ST_REPORT);
        exc_code  = rsp_valid ? exc_q : 4'd0;
        hw_err    = rsp_valid && hwerr_q;
    end

    // ---------------- assertions ----------------
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $past(req)); // R2
    AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n) req |=> rsp_valid); // R2
    AST_QUIET_CODE: assert property (@(posedge clk) disable iff (!rst_n) !rsp_valid |-> (exc_code == 4'd0 && !hw_err)); // R8
    AST_HWERR_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n) hw_err |-> exc_code == 4'd0); // R12
    AST_DFAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !req |=> ($stable(d_fault_addr) && $stable(d_fault_status))); // R9
    AST_MHIT_MASK: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && exc_code == 4'd3) |-> $countones(d_fault_status[15:0]) >= 2); // R7
    AST_MISS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && exc_code == 4'd1) |-> d_fault_status[19]); // R9

endmodule

// File: tb/prot_lookaside_chk_tb.sv
module prot_lookaside_chk_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0, req_inst = 1'b0, req_supv = 1'b0, req_dag1 = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_pc = '0;
    logic        rsp_valid, hw_err;
    logic [3:0]  exc_code;
    logic [31:0] d_fault_status, d_fault_addr, i_fault_status, i_fault_addr;

    always #5 clk = ~clk;

    prot_lookaside_chk u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .req(req), .req_addr(req_addr), .req_write(req_write),
        .req_inst(req_inst), .req_size(req_size), .req_supv(req_supv), .req_dag1(req_dag1),
        .req_pc(req_pc), .rsp_valid(rsp_valid), .exc_code(exc_code), .hw_err(hw_err),
        .d_fault_status(d_fault_status), .d_fault_addr(d_fault_addr),
        .i_fault_status(i_fault_status), .i_fault_addr(i_fault_addr)
    );

    int  nchk = 0, nfail = 0;
    bit  done = 1'b0;

    // shadow of the programmed state
    logic [31:0] t_base [16];
    logic [31:0] t_attr [16];
    bit          t_en = 1'b1;
    logic [31:0] m_dfs = 0, m_dfa = 0, m_ifs = 0, m_ifa = 0;
    logic [3:0]  e_code;
    bit          e_herr;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(logic [1:0] sel, int idx, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 4'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) t_base[idx] = d;
        else if (sel == 2'd1) t_attr[idx] = d;
        else t_en = d[0];
    endtask

    function automatic longint unsigned pgsz(logic [1:0] p);
        case (p)
            2'd0: return 64'h400;
            2'd1: return 64'h1000;
            2'd2: return 64'h10_0000;
            default: return 64'h40_0000;
        endcase
    endfunction

    // expected outcome from the requirements
    task automatic predict(logic [31:0] a, bit w, bit ins, logic [1:0] sz, bit sv, bit dg, logic [31:0] pc);
        int cnt = 0; bit pf = 0; logic [15:0] msk = 0; int cls = 0; bit lg = 0;
        int imp; // 0 none 1 ok 2 miss 3 prot 4 hwerr
        logic [31:0] st;
        e_herr = 0;
        for (int i = 0; i < 16; i++) begin
            logic [31:0] at = t_attr[i];
            if (at[0] && a >= t_base[i] && longint'(a) < longint'(t_base[i]) + longint'(pgsz(at[17:16]))) begin
                cnt++; msk[i] = 1'b1;
                if (w) begin
                    if (!sv && !at[3]) pf = 1;
                    if (sv && !at[4]) pf = 1;
                    if (at[12] && !at[14] && !at[7]) pf = 1;
                end else if (!sv && !at[2]) pf = 1;
            end
        end
        if (!t_en) msk = 0;
        if (a >= 32'hFFC0_0000) imp = ins ? 2 : ((!sv || dg) ? 3 : 1);
        else if (a[31:24] == 8'hFF) begin
            if (ins) imp = (a[31:20] == 12'hFFA) ? 1 : 3;
            else     imp = (a[31:20] == 12'hFFA) ? 4 : 1;
        end else imp = 0;
        if ((a & ((32'd1 << sz) - 1)) != 0) begin cls = 4; lg = 1; end
        else if (t_en && (pf || cnt >= 2)) begin cls = (cnt >= 2) ? 3 : 2; lg = 1; end
        else begin
            case (imp)
                0: if (t_en && cnt != 1) begin cls = 1; lg = 1; end
                2: begin cls = 1; lg = 1; end
                3: begin cls = 2; lg = 1; end
                4: e_herr = 1;
                default: ;
            endcase
        end
        e_code = {ins, 3'(cls)};
        st = {12'd0, cls == 1, dg, sv, w, msk};
        if (lg) begin
            if (ins) begin m_ifa = a; m_ifs = st; end
            else begin m_dfa = a; m_dfs = st; m_ifa = pc; m_ifs = {14'd0, sv, 17'd0}; end
        end
    endtask

    task automatic access(string tag, logic [31:0] a, bit w, bit ins, logic [1:0] sz, bit sv, bit dg);
        logic [31:0] pc = $urandom;
        predict(a, w, ins, sz, sv, dg, pc);
        @(negedge clk);
        req = 1'b1; req_addr = a; req_write = w; req_inst = ins; req_size = sz;
        req_supv = sv; req_dag1 = dg; req_pc = pc;
        @(negedge clk);
        req = 1'b0;
        chk({tag, " rsp_valid (R2)"}, 32'(rsp_valid), 32'd1);
        chk({tag, " exc_code (R8)"}, 32'(exc_code), 32'(e_code));
        chk({tag, " hw_err"}, 32'(hw_err), 32'(e_herr));
        chk({tag, " d_fault_status (R9)"}, d_fault_status, m_dfs);
        chk({tag, " d_fault_addr (R9)"}, d_fault_addr, m_dfa);
        chk({tag, " i_fault_status (R13)"}, i_fault_status, m_ifs);
        chk({tag, " i_fault_addr (R13)"}, i_fault_addr, m_ifa);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] win [4];
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 16; i++) begin t_base[i] = 0; t_attr[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 exc_code", 32'(exc_code), 0);
        chk("R1 hw_err", 32'(hw_err), 0);
        chk("R1 fault regs", d_fault_status | d_fault_addr | i_fault_status | i_fault_addr, 0);
        access("R1 enabled after reset, empty table miss", 32'h0000_1000, 0, 0, 2, 1, 0);
        chk("R1 hand miss code", 32'(exc_code), 32'd1);
        @(negedge clk);
        chk("R2 rsp_valid drops", 32'(rsp_valid), 0);

        // R10 disabled: implicit only
        cfg(2'd2, 0, 0);
        access("R10 plain address allowed", 32'h0000_1000, 0, 0, 2, 0, 0);
        access("R12 data in exec region hwerr", 32'hFFA0_0010, 0, 0, 2, 1, 0);
        chk("R12 hand hw_err", 32'(hw_err), 1);
        access("R12 fetch in L1 outside exec", 32'hFF80_0000, 0, 1, 1, 1, 0);
        chk("R12 hand prot code", 32'(exc_code), 32'd10);
        access("R12 fetch in exec region", 32'hFFA0_0100, 0, 1, 1, 0, 0);
        access("R11 fetch in system region", 32'hFFC0_0000, 0, 1, 1, 1, 0);
        chk("R11 hand miss code", 32'(exc_code), 32'd9);
        access("R11 user data in system region", 32'hFFC0_0000, 1, 0, 2, 0, 0);
        access("R11 secondary generator", 32'hFFC0_0004, 0, 0, 2, 1, 1);
        access("R11 supervisor primary", 32'hFFE0_0004, 1, 0, 2, 1, 0);
        cfg(2'd2, 0, 1);

        // R3 matching and page sizes
        cfg(2'd0, 0, 32'h0001_0000);
        cfg(2'd1, 0, 32'h0000_001D);
        access("R3 last word of 1K page", 32'h0001_03FC, 0, 0, 2, 0, 0);
        access("R3 one past 1K page", 32'h0001_0400, 0, 0, 2, 0, 0);
        access("R3 below base", 32'h0000_FFFC, 0, 0, 2, 0, 0);
        cfg(2'd1, 0, 32'h0002_001D);
        access("R3 last word of 1M page", 32'h0010_FFFC, 0, 0, 2, 0, 0);
        cfg(2'd1, 0, 32'h0002_001C);
        access("R3 invalid entry ignored", 32'h0001_0000, 0, 0, 2, 1, 0);

        // R4 write permissions
        cfg(2'd1, 0, 32'h0000_0005);
        access("R4 user write without permission", 32'h0001_0010, 1, 0, 2, 0, 0);
        chk("R4 hand status", d_fault_status, 32'h0001_0001);
        access("R4 supervisor write without permission", 32'h0001_0010, 1, 0, 2, 1, 0);
        cfg(2'd1, 0, 32'h0000_101D);
        access("R4 clean cacheable write", 32'h0001_0020, 1, 0, 2, 1, 0);
        cfg(2'd1, 0, 32'h0000_109D);
        access("R4 dirty cacheable write", 32'h0001_0020, 1, 0, 2, 1, 0);
        cfg(2'd1, 0, 32'h0000_501D);
        access("R4 write-through write", 32'h0001_0020, 1, 0, 2, 0, 0);

        // R5 read permissions
        cfg(2'd1, 0, 32'h0000_0019);
        access("R5 user read refused", 32'h0001_0030, 0, 0, 2, 0, 1);
        access("R5 supervisor read allowed", 32'h0001_0030, 0, 0, 2, 1, 0);

        // R7 multiple hits, R6 misalignment priority
        cfg(2'd0, 1, 32'h0001_0000);
        cfg(2'd1, 1, 32'h0001_001D);
        access("R7 overlap gives multi-hit", 32'h0001_0040, 0, 0, 2, 0, 0);
        chk("R7 hand mask", d_fault_status[15:0], 32'h3);
        access("R6 misaligned over overlap", 32'h0001_0042, 0, 0, 2, 0, 0);
        access("R6 misaligned fetch", 32'h0001_0041, 0, 1, 1, 1, 0);
        chk("R6 hand code", 32'(exc_code), 32'd12);
        access("R13 data fault loads fetch regs", 32'h0001_0044, 1, 0, 3, 1, 1);

        // random stimulus
        win[0] = 32'h0000_0000; win[1] = 32'h2000_0000; win[2] = 32'hFF80_0000; win[3] = 32'hFFA0_0000;
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a; logic [1:0] sz; int k;
            if (n % 60 == 0) begin
                for (int e = 0; e < 16; e++) begin
                    cfg(2'd0, e, win[$urandom % 4] + (($urandom % 16) << 10));
                    cfg(2'd1, e, ($urandom & 32'h0003_509D) | 32'(($urandom % 4) != 0));
                end
                cfg(2'd2, 0, 32'(($urandom % 5) != 0));
            end
            k = $urandom % 16;
            sz = 2'($urandom);
            case ($urandom % 8)
                0, 1, 2: a = t_base[k] + ($urandom % 32'h2000);
                3:       a = t_base[k] + 32'(pgsz(t_attr[k][17:16])) - (($urandom % 2) * 4);
                4:       a = 32'hFFC0_0000 + ($urandom % 32'h100);
                5:       a = 32'hFF80_0000 + ($urandom % 32'h30_0000);
                default: a = $urandom;
            endcase
            if ($urandom % 4 != 0) a = a & ~((32'd1 << sz) - 1);
            access("R3 R7 R9 random", a, 1'($urandom), 1'($urandom), sz, 1'($urandom), 1'($urandom));
        end
        finish_run();
    end

endmodule